// File: doc/BRIEF.md
# Two-Wire Serial Memory Target Engine

This block is the bus-facing half of a two-wire serial memory. It watches a serial clock and a serial data line, both already synchronized into the system clock domain and sampled many times per bit. It finds START and STOP conditions and accepts a device byte carrying the fixed type code 1010, three strap bits and a direction bit. It then takes a two-byte memory address and either receives data bytes or shifts data bytes out. Its only drive onto the data line is an open-drain enable: when high, the line is pulled low.

A single address counter serves both directions. Each byte written or read advances it by one, and it wraps over the whole array. This allows current-address reads, sequential reads, and random reads built from an address-only write followed by a repeated START. Received data goes to a separate page-write controller as a one-cycle strobe with address and data, and every STOP is reported as a one-cycle pulse. While that controller signals busy, the engine stays idle and acknowledges nothing. The array itself sits outside the block and returns a byte for the address on `mem_addr_o`.

Top module: `ee2w_target`

## Requirements
- R1: A device byte is accepted only when its upper four bits are 1010 and bits 3..1 equal `strap_i`; bit 0 = 1 means read and 0 means write. An accepted byte is acknowledged by pulling the line low through the ninth clock. A rejected byte gets no acknowledge, and later bytes are ignored until the next START.
- R2: A data fall while the clock is high is a START. A data rise while the clock is high is a STOP, which returns the engine to idle, releases the line and pulses `stop_o` for one cycle.
- R3: In a write, the two bytes after the device byte form the address, high byte first. High-byte bits at position AW-8 and above are ignored. Each later byte produces one `wr_stb_o` cycle carrying the byte on `wr_data_o` and the counter value on `wr_addr_o`, and the counter then advances by one.
- R4: Incoming bits are taken on the clock rise, MSB first. Outgoing bits are placed after the clock fall, MSB first. The drive enable never switches on while the clock is high.
- R5: In a read, a master acknowledge (line low at the ninth rise) starts the next byte. The counter advances by one per byte sent and wraps from 2^AW-1 to 0.
- R6: A missing master acknowledge makes the engine release the line and ignore further clocks until STOP or START.
- R7: A read that is not preceded by an address phase returns the byte at the last accessed address plus one, whether that access was a write or a read.
- R8: An address-only write followed by a repeated START and a read device byte reads from the loaded address.
- R9: While `busy_i` is high, no byte is acknowledged, the line is released by the next cycle, and a STOP gives no `stop_o` pulse.
- R10: A START in the middle of any byte drops the transfer and restarts device-byte reception.
- R11: After reset the line is released, `wr_stb_o` and `stop_o` are low and the counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronized serial clock |
| sda_i | input | 1 | Synchronized serial data (wired-AND line level) |
| strap_i | input | 3 | Board strap bits matched against device byte bits 3..1 |
| busy_i | input | 1 | Write controller busy; engine ignores the bus |
| sda_oe_o | output | 1 | Pull data line low when 1 |
| mem_addr_o | output | AW | Address counter, read address for the array |
| mem_rdata_i | input | 8 | Array byte at `mem_addr_o` |
| wr_stb_o | output | 1 | One-cycle strobe per received data byte |
| wr_addr_o | output | AW | Address of the strobed byte |
| wr_data_o | output | 8 | Strobed data byte |
| stop_o | output | 1 | One-cycle pulse on each STOP seen while not busy |

## Verification
The bench builds the engine with AW = 9, so the array is 512 bytes. This makes the wrap from 0x1FF to 0 reachable with a three-byte write or read starting near the top. Sending 0xFF as the high address byte also shows that bits 7..1 of that byte are discarded. The straps are tied to 101, so flipping the low strap bit or the type code gives the rejection cases. Each SCL phase lasts four system clocks, which leaves room to see the one-cycle latency of edge detection.

// File: rtl/ee2w_pkg.sv
`timescale 1ns/1ps
package ee2w_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RECV, ST_ACK1, ST_ACK2, ST_SEND, ST_MACK, ST_HOLD
  } st_e;

  typedef enum logic [1:0] {
    FLD_DEV, FLD_AHI, FLD_ALO, FLD_DATA
  } fld_e;

  localparam logic [3:0] DEV_CODE = 4'b1010;
endpackage

// File: rtl/ee2w_rst_sync.sv
`timescale 1ns/1ps
module ee2w_rst_sync (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) q <= 2'b00;
    else         q <= {q[0], 1'b1};
  end

  assign rst_no = q[1];
endmodule

// File: rtl/ee2w_edge.sv
`timescale 1ns/1ps
module ee2w_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise  = scl_i & ~scl_q;
  assign scl_fall  = ~scl_i & scl_q;
  assign start_det = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_det  = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/ee2w_ptr.sv
`timescale 1ns/1ps
module ee2w_ptr #(
  parameter int W = 15
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (ld)       cnt_d = ld_val;
    else if (inc) cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/ee2w_target.sv
`timescale 1ns/1ps
module ee2w_target
  import ee2w_pkg::*;
#(
  parameter int AW = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic [2:0]    strap_i,
  input  logic          busy_i,
  output logic          sda_oe_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic [7:0]    mem_rdata_i,
  output logic          wr_stb_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [7:0]    wr_data_o,
  output logic          stop_o
);
  localparam int HIW = AW - 8;

  logic rst_s;
  logic scl_rise, scl_fall, start_det, stop_det;

  ee2w_rst_sync i_rst (.clk(clk), .rst_ni(rst_n), .rst_no(rst_s));

  ee2w_edge i_edge (
    .clk(clk), .rst_n(rst_s), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  st_e             st_q, st_d;
  fld_e            fld_q, fld_d;
  logic [2:0]      bit_q, bit_d;
  logic [7:0]      sh_q, sh_d;
  logic            oe_q, oe_d;
  logic            rw_q, rw_d;
  logic [HIW-1:0]  ahi_q, ahi_d;
  logic            stb_q, stb_d;
  logic [7:0]      wdat_q, wdat_d;
  logic [AW-1:0]   waddr_q, waddr_d;
  logic            stop_q, stop_d;
  logic            ptr_ld, ptr_inc;
  logic [AW-1:0]   ptr;
  logic [7:0]      rx_byte;

  assign rx_byte = {sh_q[6:0], sda_i};

  ee2w_ptr #(.W(AW)) i_ptr (
    .clk(clk), .rst_n(rst_s), .ld(ptr_ld), .ld_val({ahi_q, rx_byte}),
    .inc(ptr_inc), .cnt(ptr)
  );

  always_comb begin
    st_d    = st_q;
    fld_d   = fld_q;
    bit_d   = bit_q;
    sh_d    = sh_q;
    oe_d    = oe_q;
    rw_d    = rw_q;
    ahi_d   = ahi_q;
    wdat_d  = wdat_q;
    waddr_d = waddr_q;
    stb_d   = 1'b0;
    stop_d  = 1'b0;
    ptr_ld  = 1'b0;
    ptr_inc = 1'b0;
    if (busy_i) begin
      st_d = ST_IDLE;
      oe_d = 1'b0;
    end else if (stop_det) begin
      st_d   = ST_IDLE;
      oe_d   = 1'b0;
      stop_d = 1'b1;
    end else if (start_det) begin
      st_d  = ST_RECV;
      fld_d = FLD_DEV;
      bit_d = 3'd0;
      oe_d  = 1'b0;
    end else begin
      case (st_q)
        ST_RECV: if (scl_rise) begin
          sh_d  = rx_byte;
          bit_d = bit_q + 3'd1;
          if (bit_q == 3'd7) begin
            st_d = ST_ACK1;
            case (fld_q)
              FLD_DEV: begin
                rw_d = rx_byte[0];
                if (rx_byte[7:4] != DEV_CODE || rx_byte[3:1] != strap_i)
                  st_d = ST_IDLE;
              end
              FLD_AHI: ahi_d = rx_byte[HIW-1:0];
              FLD_ALO: ptr_ld = 1'b1;
              default: begin
                stb_d   = 1'b1;
                wdat_d  = rx_byte;
                waddr_d = ptr;
                ptr_inc = 1'b1;
              end
            endcase
          end
        end
        ST_ACK1: if (scl_fall) begin
          oe_d = 1'b1;
          st_d = ST_ACK2;
        end
        ST_ACK2: if (scl_fall) begin
          bit_d = 3'd0;
          if (fld_q == FLD_DEV && rw_q) begin
            sh_d = mem_rdata_i;
            oe_d = ~mem_rdata_i[7];
            st_d = ST_SEND;
          end else begin
            oe_d = 1'b0;
            st_d = ST_RECV;
            case (fld_q)
              FLD_DEV: fld_d = FLD_AHI;
              FLD_AHI: fld_d = FLD_ALO;
              default: fld_d = FLD_DATA;
            endcase
          end
        end
        ST_SEND: if (scl_rise) begin
          sh_d  = rx_byte;
          bit_d = bit_q + 3'd1;
          if (bit_q == 3'd7) begin
            ptr_inc = 1'b1;
            st_d    = ST_MACK;
          end
        end else if (scl_fall) begin
          oe_d = ~sh_q[7];
        end
        ST_MACK: if (scl_fall) begin
          oe_d = 1'b0;
        end else if (scl_rise) begin
          st_d = sda_i ? ST_HOLD : ST_ACK2;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      st_q    <= ST_IDLE;
      fld_q   <= FLD_DEV;
      bit_q   <= '0;
      sh_q    <= '0;
      oe_q    <= 1'b0;
      rw_q    <= 1'b0;
      ahi_q   <= '0;
      stb_q   <= 1'b0;
      wdat_q  <= '0;
      waddr_q <= '0;
      stop_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      fld_q   <= fld_d;
      bit_q   <= bit_d;
      sh_q    <= sh_d;
      oe_q    <= oe_d;
      rw_q    <= rw_d;
      ahi_q   <= ahi_d;
      stb_q   <= stb_d;
      wdat_q  <= wdat_d;
      waddr_q <= waddr_d;
      stop_q  <= stop_d;
    end
  end

  assign sda_oe_o   = oe_q;
  assign mem_addr_o = ptr;
  assign wr_stb_o   = stb_q;
  assign wr_addr_o  = waddr_q;
  assign wr_data_o  = wdat_q;
  assign stop_o     = stop_q;
endmodule

// File: rtl/ee2w_target_chk.sv
`timescale 1ns/1ps
module ee2w_target_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_i,
  input logic busy_i,
  input logic sda_oe_o,
  input logic wr_stb_o,
  input logic stop_o
);
  // R9
  busy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> !sda_oe_o);

  // R4
  drive_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_o) |-> !$past(scl_i));

  // R3
  stb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |=> !wr_stb_o);

  // R2
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_o |-> !sda_oe_o);

  // R9
  stop_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_o |-> !$past(busy_i));
endmodule

bind ee2w_target ee2w_target_chk i_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .busy_i(busy_i),
  .sda_oe_o(sda_oe_o), .wr_stb_o(wr_stb_o), .stop_o(stop_o)
);

// File: tb/test_ee2w_target.sv
`timescale 1ns/1ps
module test_ee2w_target;
  localparam int AW = 9;
  localparam logic [2:0] STRAP = 3'b101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic busy = 1'b0;
  logic sda_line;
  logic sda_oe;
  logic [AW-1:0] mem_addr, wr_addr;
  logic [7:0] rdata, wr_data;
  logic wr_stb, stop_p;

  logic [7:0] mem [0:(1<<AW)-1];
  logic [AW-1:0] log_a [0:15];
  logic [7:0]    log_d [0:15];
  int total = 0, bad = 0, stb_cnt = 0, stop_cnt = 0, oe_cnt = 0, viol = 0, cyc = 0;
  logic oe_prev = 1'b0;
  bit done = 0;

  always #4 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;
  assign rdata = mem[mem_addr];

  ee2w_target #(.AW(AW)) i_ee2w_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .strap_i(STRAP),
    .busy_i(busy), .sda_oe_o(sda_oe), .mem_addr_o(mem_addr), .mem_rdata_i(rdata),
    .wr_stb_o(wr_stb), .wr_addr_o(wr_addr), .wr_data_o(wr_data), .stop_o(stop_p)
  );

  always @(posedge clk) begin
    #1;
    if (wr_stb) begin
      mem[wr_addr] = wr_data;
      log_a[stb_cnt % 16] = wr_addr;
      log_d[stb_cnt % 16] = wr_data;
      stb_cnt++;
    end
    if (stop_p) stop_cnt++;
    if (sda_oe) oe_cnt++;
    if (sda_oe && !oe_prev && scl) viol++;
    oe_prev = sda_oe;
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: act=%0d exp<=150000 cycles", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic ph();
    repeat (4) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; ph(); scl = 1'b1; ph(); sda_m = 1'b0; ph(); scl = 1'b0; ph();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; ph(); scl = 1'b1; ph(); sda_m = 1'b1; ph();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; ph(); scl = 1'b1; ph(); scl = 1'b0; ph();
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic nak);
    send_bits(b, 8);
    sda_m = 1'b1; ph(); scl = 1'b1; ph(); nak = sda_line; scl = 1'b0; ph();
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      ph(); scl = 1'b1; ph(); b[i] = sda_line; scl = 1'b0;
    end
    ph(); sda_m = mack; ph(); scl = 1'b1; ph(); scl = 1'b0; ph(); sda_m = 1'b1;
  endtask

  function automatic logic [7:0] init_val(input int a);
    return 8'(a) ^ 8'h3C;
  endfunction

  task automatic t_reset();
    chk(sda_oe == 1'b0, "R11 oe", 32'(sda_oe), 0);
    chk(wr_stb == 1'b0, "R11 stb", 32'(wr_stb), 0);
    chk(stop_p == 1'b0, "R11 stop", 32'(stop_p), 0);
    chk(mem_addr == '0, "R11 counter", 32'(mem_addr), 0);
  endtask

  task automatic t_reject();
    logic nak;
    int s0;
    s0 = stb_cnt;
    bus_start();
    send_byte({4'b1010, STRAP ^ 3'b001, 1'b0}, nak);
    chk(nak == 1'b1, "R1 strap mismatch nak", 32'(nak), 1);
    send_byte(8'h00, nak);
    chk(nak == 1'b1, "R1 idle until START", 32'(nak), 1);
    bus_stop();
    bus_start();
    send_byte({4'b1011, STRAP, 1'b0}, nak);
    chk(nak == 1'b1, "R1 type code mismatch", 32'(nak), 1);
    bus_stop();
    chk(stb_cnt == s0, "R1 no strobe", 32'(stb_cnt - s0), 0);
  endtask

  task automatic t_write();
    logic nak;
    int s0, p0, k;
    logic [7:0] d [3];
    d[0] = 8'hA1; d[1] = 8'hB2; d[2] = 8'hC3;
    s0 = stb_cnt; p0 = stop_cnt;
    bus_start();
    send_byte({4'b1010, STRAP, 1'b0}, nak);
    chk(nak == 1'b0, "R1 match ack", 32'(nak), 0);
    send_byte(8'hFF, nak);
    chk(nak == 1'b0, "R3 high addr ack", 32'(nak), 0);
    send_byte(8'hFE, nak);
    chk(nak == 1'b0, "R3 low addr ack", 32'(nak), 0);
    for (int i = 0; i < 3; i++) begin
      send_byte(d[i], nak);
      chk(nak == 1'b0, "R3 data ack", 32'(nak), 0);
    end
    bus_stop();
    chk(stb_cnt - s0 == 3, "R3 strobe count", 32'(stb_cnt - s0), 3);
    for (int i = 0; i < 3; i++) begin
      k = (s0 + i) % 16;
      chk(log_a[k] == AW'(9'h1FE + i), "R3 strobe addr", 32'(log_a[k]), 32'(AW'(9'h1FE + i)));
      chk(log_d[k] == d[i], "R3 strobe data", 32'(log_d[k]), 32'(d[i]));
    end
    chk(stop_cnt - p0 == 1, "R2 stop pulse", 32'(stop_cnt - p0), 1);
    chk(mem_addr == AW'(1), "R7 counter after write", 32'(mem_addr), 1);
  endtask

  task automatic t_cur_read();
    logic nak;
    logic [7:0] b;
    bus_start();
    send_byte({4'b1010, STRAP, 1'b1}, nak);
    chk(nak == 1'b0, "R1 read ack", 32'(nak), 0);
    recv_byte(1'b1, b);
    chk(b == init_val(1), "R7 current address read", 32'(b), 32'(init_val(1)));
    bus_stop();
    chk(mem_addr == AW'(2), "R5 counter advance", 32'(mem_addr), 2);
  endtask

  task automatic t_rand_seq();
    logic nak;
    logic [7:0] b;
    int o0;
    bus_start();
    send_byte({4'b1010, STRAP, 1'b0}, nak);
    send_byte(8'h01, nak);
    send_byte(8'hFF, nak);
    chk(nak == 1'b0, "R8 address-only write ack", 32'(nak), 0);
    bus_start();
    send_byte({4'b1010, STRAP, 1'b1}, nak);
    chk(nak == 1'b0, "R8 repeated START read ack", 32'(nak), 0);
    recv_byte(1'b0, b);
    chk(b == 8'hB2, "R8 random read byte", 32'(b), 32'hB2);
    recv_byte(1'b0, b);
    chk(b == 8'hC3, "R5 wrap to zero", 32'(b), 32'hC3);
    recv_byte(1'b1, b);
    chk(b == init_val(1), "R5 sequential third", 32'(b), 32'(init_val(1)));
    o0 = oe_cnt;
    send_bits(8'h00, 8);
    send_bits(8'h00, 1);
    chk(oe_cnt == o0, "R6 released after nak", 32'(oe_cnt - o0), 0);
    bus_stop();
  endtask

  task automatic t_busy();
    logic nak;
    int p0, o0;
    busy = 1'b1;
    p0 = stop_cnt;
    ph();
    o0 = oe_cnt;
    bus_start();
    send_byte({4'b1010, STRAP, 1'b0}, nak);
    chk(nak == 1'b1, "R9 busy nak", 32'(nak), 1);
    bus_stop();
    chk(stop_cnt == p0, "R9 no stop pulse", 32'(stop_cnt - p0), 0);
    chk(oe_cnt == o0, "R9 line released", 32'(oe_cnt - o0), 0);
    busy = 1'b0;
    ph();
  endtask

  task automatic t_restart();
    logic nak;
    logic [7:0] b;
    bus_start();
    send_byte({4'b1010, STRAP, 1'b0}, nak);
    send_bits(8'h01, 5);
    bus_start();
    send_byte({4'b1010, STRAP, 1'b1}, nak);
    chk(nak == 1'b0, "R10 restart ack", 32'(nak), 0);
    recv_byte(1'b1, b);
    chk(b == init_val(2), "R10 read after abort", 32'(b), 32'(init_val(2)));
    bus_stop();
  endtask

  initial begin
    for (int i = 0; i < (1 << AW); i++) mem[i] = init_val(i);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_reject();
    t_write();
    t_cur_read();
    t_rand_seq();
    t_busy();
    t_restart();
    chk(viol == 0, "R4 drive only while clock low", 32'(viol), 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule